// File: doc/BRIEF.md
# Fractional audio bit-clock divider

The block derives an audio bit clock from a faster parent clock by dividing by a programmable ratio that need not be an integer. A single 32-bit control word sets the ratio. Its integer part is twice an 8-bit count plus a one-bit half step. Its fractional part is an 8-bit numerator over an 8-bit denominator. Software normally loads the denominator with 255.

Each output period lasts the integer part in parent cycles. A phase accumulator adds the numerator once per period. Whenever the sum reaches the denominator, the denominator is taken off and that period is stretched by one cycle. The average ratio therefore comes out exact, and the error never exceeds one parent cycle.

Software writes the control word and reads it back unchanged. A new ratio is picked up only at a period boundary, so a write never truncates a period in progress. An active-low enable bit starts and stops the output. The block also emits a one-cycle tick in the last parent cycle of every output period.

Top module: `frac_bclk_div`

## Requirements
- R1: After synchronous reset, `rd_data` reads 32'h0200_0000 (stop bit 25 set, every ratio field zero), and `bclk_o` and `tick_o` are low.
- R2: A word written with `wr_en` appears unchanged on `rd_data` in the cycle after the write, all 32 bits included.
- R3: Each output period lasts B or B+1 parent cycles, where B = 2*bits[23:16] + bit[24], raised to 2 when that sum is below 2.
- R4: Counting from enable, the first N periods contain exactly floor(N*num/den) stretched periods, where num is bits[7:0] and den is bits[15:8].
- R5: A numerator larger than the denominator acts as equal to it, so every period is stretched. A denominator of zero stretches no period.
- R6: In each period `bclk_o` is high for the first floor(L/2) cycles and low for the rest, where L is the period length. `tick_o` is high only in the last cycle of each period.
- R7: While bit 25 is 1, `bclk_o` and `tick_o` stay low from the second cycle after the write that set it.
- R8: Clearing bit 25 starts a period in the cycle after the write, with `bclk_o` high, the cycle count at zero and the phase accumulator cleared.
- R9: A ratio written during a period leaves that period's length unchanged. The new ratio applies from the next period.
- R10: Bit 28 and the other bits outside 28:0's decoded fields are stored only. They do not change the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word to store |
| bclk_o | output | 1 | Divided bit clock |
| tick_o | output | 1 | One-cycle pulse in the last cycle of each output period |
| rd_data | output | 32 | Stored control word |

## Verification
The hardest situation to reach from the ports is a ratio write that lands in the middle of a period. Its effect only shows as one period keeping the old length while the next takes the new one. The bench reaches it by issuing the write from inside its cycle-counting loop at a chosen cycle of the first period, then comparing the recorded length of each period. Accumulator behaviour is checked with random numerators and denominators against a closed-form count of stretched periods. Every measurement begins from a fresh disable and re-enable, so the accumulator starts cleared.

// File: rtl/frac_bclk_div.sv
module frac_bclk_div #(
  parameter int CW = 32,
  parameter int FW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_data,
  output logic          bclk_o,
  output logic          tick_o,
  output logic [CW-1:0] rd_data
);
  localparam int BW      = FW + 1;
  localparam int LW      = FW + 2;
  localparam int STOP_B  = 25;
  localparam int STEP_B  = 24;
  localparam int INT_LSB = 16;
  localparam int DEN_LSB = 8;
  localparam logic [CW-1:0] RST_WORD = CW'(1) << STOP_B;

  logic [CW-1:0] ctrl;
  logic          run;
  logic [LW-1:0] cnt, len;
  logic [FW-1:0] acc;

  wire [FW-1:0] f_num  = ctrl[FW-1:0];
  wire [FW-1:0] f_den  = ctrl[DEN_LSB +: FW];
  wire [FW-1:0] f_int  = ctrl[INT_LSB +: FW];
  wire          f_step = ctrl[STEP_B];
  wire          en     = ~ctrl[STOP_B];

  wire [BW-1:0] raw    = {f_int, 1'b0} + BW'(f_step);
  wire [BW-1:0] base   = (raw < BW'(2)) ? BW'(2) : raw;
  wire [FW-1:0] numc   = (f_num > f_den) ? f_den : f_num;
  wire [BW-1:0] sum    = {1'b0, acc} + {1'b0, numc};
  wire          stretch = (f_den != '0) && (sum >= {1'b0, f_den});
  wire          last   = run && (cnt == len - LW'(1));
  wire          bound  = !run || last;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= RST_WORD;
      run  <= 1'b0;
      cnt  <= '0;
      len  <= LW'(2);
      acc  <= '0;
    end else begin
      if (wr_en) ctrl <= wr_data;
      if (!en) begin
        run <= 1'b0;
        cnt <= '0;
        acc <= '0;
      end else if (bound) begin
        run <= 1'b1;
        cnt <= '0;
        len <= LW'(base) + LW'(stretch);
        acc <= stretch ? FW'(sum - {1'b0, f_den}) : sum[FW-1:0];
      end else begin
        cnt <= cnt + LW'(1);
      end
    end
  end

  assign bclk_o  = run && (cnt < (len >> 1));
  assign tick_o  = last;
  assign rd_data = ctrl;
endmodule

module frac_bclk_div_chk (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic        bclk_o,
  input logic        tick_o,
  input logic [31:0] rd_data
);
  // R2: readback equals the last write
  a_r2_readback: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en) && !$past(rst) |-> rd_data == $past(wr_data));

  // R7: held stop bit silences both outputs
  a_r7_stopped_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rd_data[25]) && rd_data[25] |-> !bclk_o && !tick_o);

  // R6: tick falls in the low phase
  a_r6_tick_in_low: assert property (@(posedge clk) disable iff (rst)
    tick_o |-> !bclk_o);

  // R6: a new period opens with the high phase when still enabled
  a_r6_next_high: assert property (@(posedge clk) disable iff (rst)
    tick_o && !rd_data[25] |=> bclk_o);

  // R1: reset state
  a_r1_reset_word: assert property (@(posedge clk)
    $past(rst) |-> rd_data == 32'h0200_0000 && !bclk_o && !tick_o);
endmodule

bind frac_bclk_div frac_bclk_div_chk u_chk (.*);

// File: tb/tb_frac_bclk_div.sv
`timescale 1ns/1ps
module tb_frac_bclk_div;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        bclk_o, tick_o;
  logic [31:0] rd_data;

  int n_tests = 0;
  int n_fail  = 0;
  int plen [0:63];

  always #2.5 clk = ~clk;

  frac_bclk_div dut (.*);

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(int ig, int st, int num, int den, bit b28, bit stop);
    return {3'b0, b28, 2'b0, stop, st[0], ig[7:0], den[7:0], num[7:0]};
  endfunction

  function automatic int base_of(logic [31:0] w);
    int b = 2 * int'(w[23:16]) + int'(w[24]);
    return (b < 2) ? 2 : b;
  endfunction

  function automatic int exp_total(int n, logic [31:0] w);
    int den = int'(w[15:8]);
    int num = int'(w[7:0]);
    if (num > den) num = den;
    return n * base_of(w) + ((den == 0) ? 0 : (n * num) / den);
  endfunction

  task automatic wr(input logic [31:0] w);
    @(negedge clk);
    wr_en = 1'b1; wr_data = w;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_periods(input int n, input int mid_at, input logic [31:0] mid_w,
                             output int total, output int bad);
    int cur = 0, hi = 0, got = 0, s = 0;
    bit seen_low = 0;
    total = 0; bad = 0;
    while (got < n && s < n * 600 + 100) begin
      @(negedge clk);
      if (mid_at > 0 && s == mid_at) begin wr_en = 1'b1; wr_data = mid_w; end
      else wr_en = 1'b0;
      cur++;
      if (bclk_o) begin hi++; if (seen_low) bad++; end
      else seen_low = 1;
      if (tick_o) begin
        if (hi != cur / 2) bad++;
        plen[got] = cur; total += cur; got++;
        cur = 0; hi = 0; seen_low = 0;
      end
      s++;
    end
    wr_en = 1'b0;
    if (got < n) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog periods actual=%0d expected=%0d", got, n);
    end
  endtask

  task automatic restart(input logic [31:0] w);
    wr(w | 32'h0200_0000);
    repeat (3) @(negedge clk);
    wr(w & ~32'h0200_0000);
  endtask

  task automatic measure(input string req, input logic [31:0] w, input int n);
    int tot, bad, b;
    restart(w);
    run_periods(n, 0, '0, tot, bad);
    check(tot == exp_total(n, w), req, tot, exp_total(n, w));
    check(bad == 0, {req, "/R6 shape"}, bad, 0);
    b = base_of(w);
    for (int i = 0; i < n; i++)
      if (plen[i] != b && plen[i] != b + 1) check(0, {req, "/R3 len"}, plen[i], b);
  endtask

  initial begin
    #(5.0 * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog global actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int tot, bad;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check(rd_data == 32'h0200_0000, "R1 word", rd_data, 32'h0200_0000);
    check(!bclk_o && !tick_o, "R1 outs", {bclk_o, tick_o}, 0);

    // R2
    for (int i = 0; i < 4; i++) begin
      logic [31:0] w = $urandom | 32'h0200_0000;
      wr(w);
      check(rd_data == w, "R2 readback", rd_data, w);
    end

    // R3 clamp and step
    measure("R3 clamp0", mk(0, 0, 0, 255, 0, 0), 10);
    measure("R3 clamp1", mk(0, 1, 0, 255, 0, 0), 10);
    measure("R3 step", mk(3, 1, 0, 255, 0, 0), 8);
    // R4 fractional
    measure("R4 frac", mk(4, 0, 100, 255, 0, 0), 30);
    measure("R4 smallden", mk(2, 1, 3, 7, 0, 0), 21);
    // R5
    measure("R5 num>den", mk(3, 0, 200, 4, 0, 0), 10);
    measure("R5 den0", mk(3, 0, 77, 0, 0, 0), 10);
    // R10
    measure("R10 bit28", mk(4, 0, 100, 255, 1, 0) | 32'hC000_0000, 30);

    // R8: first sample after enable is high, and restart repeats the sequence
    restart(mk(5, 0, 128, 255, 0, 0));
    @(negedge clk);
    check(bclk_o == 1'b1, "R8 first high", bclk_o, 1);
    restart(mk(5, 0, 128, 255, 0, 0));
    run_periods(12, 0, '0, tot, bad);
    check(tot == exp_total(12, mk(5, 0, 128, 255, 0, 0)), "R8 acc cleared", tot,
          exp_total(12, mk(5, 0, 128, 255, 0, 0)));

    // R9 mid-period write
    restart(mk(5, 0, 0, 255, 0, 0));
    run_periods(3, 3, mk(2, 0, 0, 255, 0, 0), tot, bad);
    check(plen[0] == 10, "R9 old period kept", plen[0], 10);
    check(plen[1] == 4, "R9 new ratio next", plen[1], 4);

    // R7 stop
    wr(mk(2, 0, 0, 255, 0, 1));
    @(negedge clk);
    begin
      int act = 0;
      for (int i = 0; i < 50; i++) begin
        @(negedge clk);
        if (bclk_o || tick_o) act++;
      end
      check(act == 0, "R7 stopped", act, 0);
    end

    // random configurations
    for (int k = 0; k < 12; k++) begin
      int ig  = $urandom % 12;
      int st  = $urandom % 2;
      int num = $urandom % 256;
      int den = ($urandom % 4 == 0) ? ($urandom % 256) : 255;
      measure("R4 random", mk(ig, st, num, den, $urandom % 2, 0), 16);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule